// File: doc/BRIEF.md
# Cluster Power Controller Register Interface

This block is a memory-mapped slave that stands in for the power controller of a two-cluster processor subsystem, as a host processor sees it. The host asks for a new operating point for a cluster by writing an index into that cluster's performance-level register. It fetches packed operating-point words (voltage and frequency) from a small internal table by writing a command word. Every request runs for a programmable number of clock cycles. Its outcome is then posted as a completion or error flag in a shared status word, and a level interrupt is raised.

Only one request can be in flight at a time. The host waits for the interrupt and reads the status word, which also clears it. Then it reads back either the index now in force or the fetched table word. The latency is a parameter in clock cycles. A real controller needs milliseconds, and a bench can set a handful of cycles instead.

Top module: `pwrctl_regif`

## Requirements
- R1: After reset both performance indices, both requested indices, the command register, the config words, the status word and the read data are zero, and `irq` is low.
- R2: A write to offset 0x00 (cluster 0, request type 0) or 0x08 (cluster 1, type 1) with an index below that cluster's entry count starts a change. On completion the status bit 4t is set, and a read of the same offset then returns the new index. Until then the read returns the previous index.
- R3: A performance write whose index is at or above the cluster's entry count (NUM_C0 or NUM_C1) completes with status bit 4t+1 set, and the index in force stays unchanged.
- R4: The outcome of a request accepted at clock edge k appears in the status word and on `irq` right after edge k+LATENCY, and not earlier. `irq` is high exactly while the status word is non-zero.
- R5: A write to the command offset 0x10 starts a configuration request (type 2) only when bit 31 is set. The function code sits in bits 27:20 and the word offset (byte offset divided by four) in bits 19:0. A write with bit 31 clear is stored but starts nothing. A read of 0x10 returns the last stored command word.
- R6: Function code 6 reads the operating-point table. Cluster 0 entry i is at word offset 0x304+i and cluster 1 entry i at 0x30C+i. Each entry holds the voltage in mV in bits 31:20 and the frequency in 20 kHz units in bits 19:0. Cluster 0 uses 900+25i mV and 25000+5000i units, and cluster 1 uses 850+25i mV and 17500+2500i units. On success status bit 8 is set and the word appears at read-data offset 0x74.
- R7: A code-6 read of an offset outside the populated entries, or a command with any code other than 6 or 14, completes with status bit 9 set and leaves the word at 0x74 unchanged.
- R8: Function code 14 completes with bit 8 set. It places a snapshot of the indices in force at 0x74: cluster 0 in bits 3:0, cluster 1 in bits 7:4, all other bits zero.
- R9: While a request is in flight, writes to 0x00, 0x08 and 0x10 are ignored, and offset 0x14 reads 1 in bit 0. It reads 0 when idle.
- R10: A read of offset 0x18 returns the status word and clears it, so `irq` falls after that edge. A result arriving on the same edge as the read is kept. A read of offset 0x1C returns the same word without clearing it.
- R11: Status flags from several requests accumulate until the status word is read.
- R12: `bus_rdata` holds the value of the register read at the edge where `bus_rd` was sampled, from that edge on. Offsets 0x04 and 0x0C return the last accepted requested index (low 8 bits of the write). Offset 0x70 is a plain read/write word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Active-high level interrupt, set while any status flag is set |

## Verification
A request accepted at edge k has its outcome due right after edge k+LATENCY. The bench samples `irq` at the falling edge after edge k+LATENCY-1, where it must still be low, and at the falling edge after edge k+LATENCY, where it must be high. Read data is due one edge after the read strobe is sampled, so every read drives its strobe on a falling edge and takes the value on the next falling edge. The walk through the stimulus table always waits LATENCY+1 cycles before it reads the status word. A directed case times a status read to land on the very completion edge: it returns the old word, and the new flag must survive.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;

    localparam int STAT_W = 12;

    typedef enum logic [1:0] {
        REQ_C0  = 2'd0,
        REQ_C1  = 2'd1,
        REQ_CFG = 2'd2
    } req_type_e;

    localparam logic [7:0] OFF_PERF0 = 8'h00;
    localparam logic [7:0] OFF_PREQ0 = 8'h04;
    localparam logic [7:0] OFF_PERF1 = 8'h08;
    localparam logic [7:0] OFF_PREQ1 = 8'h0C;
    localparam logic [7:0] OFF_CMD   = 8'h10;
    localparam logic [7:0] OFF_BUSY  = 8'h14;
    localparam logic [7:0] OFF_STAT  = 8'h18;
    localparam logic [7:0] OFF_FLAG  = 8'h1C;
    localparam logic [7:0] OFF_WDAT  = 8'h70;
    localparam logic [7:0] OFF_RDAT  = 8'h74;

    localparam logic [7:0] FN_TABLE  = 8'd6;
    localparam logic [7:0] FN_SNAP   = 8'd14;

    localparam int C0_WBASE = 'h304;
    localparam int C1_WBASE = 'h30C;

    function automatic logic [31:0] opp_word(input int cl, input int idx);
        int mv;
        int fu;
        if (cl == 0) begin
            mv = 900 + 25 * idx;
            fu = 25000 + 5000 * idx;
        end else begin
            mv = 850 + 25 * idx;
            fu = 17500 + 2500 * idx;
        end
        return {12'(mv), 20'(fu)};
    endfunction

endpackage

// File: rtl/pwrctl_opp_rom.sv
module pwrctl_opp_rom
    import pwrctl_pkg::*;
#(
    parameter int MAX_ENTRIES = 8,
    parameter int NUM_C0      = 5,
    parameter int NUM_C1      = 3
) (
    input  logic [19:0] woff,
    output logic        hit,
    output logic [31:0] word
);
    localparam int NCL = 2;

    logic [31:0] tbl [NCL][MAX_ENTRIES];
    int          cnt [NCL];
    int          base[NCL];

    assign cnt[0]  = NUM_C0;
    assign cnt[1]  = NUM_C1;
    assign base[0] = C0_WBASE;
    assign base[1] = C1_WBASE;

    for (genvar c = 0; c < NCL; c++) begin : g_cl
        for (genvar i = 0; i < MAX_ENTRIES; i++) begin : g_ent
            assign tbl[c][i] = opp_word(c, i);
        end
    end

    always_comb begin
        hit  = 1'b0;
        word = '0;
        for (int c = 0; c < NCL; c++) begin
            for (int i = 0; i < MAX_ENTRIES; i++) begin
                if (i < cnt[c] && woff == 20'(base[c] + i)) begin
                    hit  = 1'b1;
                    word = tbl[c][i];
                end
            end
        end
    end

    initial begin
        assert (NUM_C0 <= MAX_ENTRIES && NUM_C1 <= MAX_ENTRIES && MAX_ENTRIES <= 16)
            else $error("a_r6_table_size: entry counts exceed table depth");
    end
endmodule

// File: rtl/pwrctl_req_seq.sv
module pwrctl_req_seq
    import pwrctl_pkg::*;
#(
    parameter int LATENCY = 400000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  req_type_e   start_type,
    input  logic        start_err,
    input  logic [31:0] start_data,
    output logic        busy,
    output logic        done,
    output req_type_e   done_type,
    output logic        done_err,
    output logic [31:0] done_data
);
    localparam int CNT_W = $clog2(LATENCY + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        req_type_e        typ;
        logic             err;
        logic [31:0]      data;
    } seq_t;

    seq_t s_d, s_q;

    assign busy      = s_q.busy;
    assign done      = s_q.busy && (s_q.cnt == '0);
    assign done_type = s_q.typ;
    assign done_err  = s_q.err;
    assign done_data = s_q.data;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (s_q.cnt == '0) s_d.busy = 1'b0;
            else               s_d.cnt  = s_q.cnt - 1'b1;
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNT_W'(LATENCY - 1);
            s_d.typ  = start_type;
            s_d.err  = start_err;
            s_d.data = start_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{busy: 1'b0, cnt: '0, typ: REQ_C0, err: 1'b0, data: '0};
        else        s_q <= s_d;
    end

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.cnt < CNT_W'(LATENCY)));

    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != '0) |=> (s_q.busy && $stable(s_q.typ) && $stable(s_q.data)));

    a_r4_done_once: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/pwrctl_regif.sv
module pwrctl_regif
    import pwrctl_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int LATENCY     = 400000,
    parameter int MAX_ENTRIES = 8,
    parameter int NUM_C0      = 5,
    parameter int NUM_C1      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int IDX_W = $clog2(MAX_ENTRIES);

    typedef struct packed {
        logic [IDX_W-1:0]  perf0;
        logic [IDX_W-1:0]  perf1;
        logic [7:0]        req0;
        logic [7:0]        req1;
        logic [31:0]       cmd;
        logic [31:0]       wdat;
        logic [31:0]       cfg_rd;
        logic [STAT_W-1:0] status;
        logic [31:0]       rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic        seq_start, seq_err, seq_busy, seq_done, done_err;
    req_type_e   seq_type, done_type;
    logic [31:0] seq_data, done_data;
    logic        rom_hit;
    logic [31:0] rom_word;

    logic        wr_p0, wr_p1, wr_cmd, rd_stat;
    logic [7:0]  fn_code;
    logic [3:0]  flag_pos;

    pwrctl_opp_rom #(
        .MAX_ENTRIES(MAX_ENTRIES), .NUM_C0(NUM_C0), .NUM_C1(NUM_C1)
    ) u_rom (
        .woff(bus_wdata[19:0]), .hit(rom_hit), .word(rom_word)
    );

    pwrctl_req_seq #(.LATENCY(LATENCY)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(seq_start), .start_type(seq_type), .start_err(seq_err),
        .start_data(seq_data),
        .busy(seq_busy), .done(seq_done), .done_type(done_type),
        .done_err(done_err), .done_data(done_data)
    );

    assign bus_rdata = r_q.rdata;
    assign irq       = |r_q.status;

    always_comb begin
        r_d       = r_q;
        seq_start = 1'b0;
        seq_type  = REQ_C0;
        seq_err   = 1'b0;
        seq_data  = '0;
        wr_p0     = bus_wr && (bus_addr == ADDR_W'(OFF_PERF0));
        wr_p1     = bus_wr && (bus_addr == ADDR_W'(OFF_PERF1));
        wr_cmd    = bus_wr && (bus_addr == ADDR_W'(OFF_CMD));
        rd_stat   = bus_rd && (bus_addr == ADDR_W'(OFF_STAT));
        fn_code   = bus_wdata[27:20];
        flag_pos  = {1'b0, done_type, 1'b0} << 1;

        // request launch: only when idle
        if (!seq_busy) begin
            if (wr_p0) begin
                seq_start = 1'b1;
                seq_type  = REQ_C0;
                seq_err   = bus_wdata >= 32'(NUM_C0);
                r_d.req0  = bus_wdata[7:0];
            end else if (wr_p1) begin
                seq_start = 1'b1;
                seq_type  = REQ_C1;
                seq_err   = bus_wdata >= 32'(NUM_C1);
                r_d.req1  = bus_wdata[7:0];
            end else if (wr_cmd) begin
                r_d.cmd = bus_wdata;
                if (bus_wdata[31]) begin
                    seq_start = 1'b1;
                    seq_type  = REQ_CFG;
                    if (fn_code == FN_TABLE) begin
                        seq_err  = !rom_hit;
                        seq_data = rom_word;
                    end else if (fn_code == FN_SNAP) begin
                        seq_data = {24'b0, 4'(r_q.perf1), 4'(r_q.perf0)};
                    end else begin
                        seq_err = 1'b1;
                    end
                end
            end
        end

        if (bus_wr && bus_addr == ADDR_W'(OFF_WDAT)) r_d.wdat = bus_wdata;

        // destructive status read, then new results
        if (rd_stat) r_d.status = '0;
        if (seq_done) begin
            r_d.status[flag_pos + {3'b0, done_err}] = 1'b1;
            if (!done_err) begin
                case (done_type)
                    REQ_C0:  r_d.perf0  = r_q.req0[IDX_W-1:0];
                    REQ_C1:  r_d.perf1  = r_q.req1[IDX_W-1:0];
                    default: r_d.cfg_rd = done_data;
                endcase
            end
        end

        if (bus_rd) begin
            case (bus_addr)
                ADDR_W'(OFF_PERF0): r_d.rdata = 32'(r_q.perf0);
                ADDR_W'(OFF_PREQ0): r_d.rdata = 32'(r_q.req0);
                ADDR_W'(OFF_PERF1): r_d.rdata = 32'(r_q.perf1);
                ADDR_W'(OFF_PREQ1): r_d.rdata = 32'(r_q.req1);
                ADDR_W'(OFF_CMD):   r_d.rdata = r_q.cmd;
                ADDR_W'(OFF_BUSY):  r_d.rdata = 32'(seq_busy);
                ADDR_W'(OFF_STAT):  r_d.rdata = 32'(r_q.status);
                ADDR_W'(OFF_FLAG):  r_d.rdata = 32'(r_q.status);
                ADDR_W'(OFF_WDAT):  r_d.rdata = r_q.wdat;
                ADDR_W'(OFF_RDAT):  r_d.rdata = r_q.cfg_rd;
                default:            r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    a_r2_perf0_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.perf0) |-> $past(seq_done && done_type == REQ_C0 && !done_err));

    a_r3_perf1_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.perf1) |-> $past(seq_done && done_type == REQ_C1 && !done_err));

    a_r7_err_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && done_err) |=> $stable(r_q.cfg_rd));

    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !seq_done) |=> (r_q.status == '0 && !irq));

    a_r9_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> !seq_start);
endmodule

// File: tb/pwrctl_regif_bench.sv
`timescale 1ns/1ps
module pwrctl_regif_bench;
    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    pwrctl_regif #(.LATENCY(LAT)) u_pwrctl_regif (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [11:0] exp_stat;
        logic [7:0]  raddr;
        logic [31:0] exp_rd;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 32'd3,         12'h001, 8'h00, 32'd3},          // R2 cluster 0 in range
        '{8'h00, 32'd5,         12'h002, 8'h00, 32'd3},          // R3 index equal to count
        '{8'h08, 32'd2,         12'h010, 8'h08, 32'd2},          // R2 cluster 1 last entry
        '{8'h08, 32'd3,         12'h020, 8'h08, 32'd2},          // R3 cluster 1 at count
        '{8'h10, 32'h8060_0304, 12'h100, 8'h74, 32'h3840_61A8},  // R6 cluster 0 entry 0
        '{8'h10, 32'h8060_0312, 12'h200, 8'h74, 32'h3840_61A8},  // R7 missing cluster 1 entry
        '{8'h10, 32'h8060_030E, 12'h100, 8'h74, 32'h3840_57E4},  // R6 cluster 1 entry 2
        '{8'h10, 32'h8030_0000, 12'h200, 8'h74, 32'h3840_57E4},  // R7 unknown code
        '{8'h10, 32'h80E0_0000, 12'h100, 8'h74, 32'h0000_0023},  // R8 index snapshot
        '{8'h10, 32'h8060_0308, 12'h100, 8'h74, 32'h3E80_AFC8},  // R6 cluster 0 entry 4
        '{8'h10, 32'h8060_0300, 12'h200, 8'h74, 32'h3E80_AFC8}   // R7 offset below table
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_result();
        repeat (LAT + 1) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", 32'(irq), 32'd0);
        bus_read(8'h00, v); check("R1 perf0", v, 32'd0);
        bus_read(8'h08, v); check("R1 perf1", v, 32'd0);
        bus_read(8'h18, v); check("R1 status", v, 32'd0);
        bus_read(8'h74, v); check("R1 cfg read data", v, 32'd0);
        bus_read(8'h10, v); check("R1 command", v, 32'd0);

        // table walk: R2 R3 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i].waddr, VEC[i].wdata);
            wait_result();
            check($sformatf("R11 irq set, vector %0d", i), 32'(irq), 32'd1);
            bus_read(8'h18, v);
            check($sformatf("R2 R3 R6 R7 R8 status, vector %0d", i), v, 32'(VEC[i].exp_stat));
            bus_read(VEC[i].raddr, v);
            check($sformatf("R2 R3 R6 R7 R8 readback, vector %0d", i), v, VEC[i].exp_rd);
        end

        // R12 requested index registers and config write word
        bus_read(8'h04, v); check("R12 request index c0", v, 32'd5);
        bus_read(8'h0C, v); check("R12 request index c1", v, 32'd3);
        bus_write(8'h70, 32'hDEAD_BEEF);
        bus_read(8'h70, v); check("R12 config write word", v, 32'hDEAD_BEEF);

        // R4 exact latency
        bus_write(8'h00, 32'd1);
        repeat (LAT - 1) @(negedge clk);
        check("R4 irq not early", 32'(irq), 32'd0);
        @(negedge clk);
        check("R4 irq on time", 32'(irq), 32'd1);
        // R10 flag view does not clear, status read clears
        bus_read(8'h1C, v); check("R10 flag view", v, 32'h001);
        check("R10 irq kept after flag read", 32'(irq), 32'd1);
        bus_read(8'h18, v); check("R10 status read", v, 32'h001);
        check("R10 irq dropped", 32'(irq), 32'd0);

        // R5 command without start bit
        bus_write(8'h10, 32'h0060_0304);
        repeat (LAT + 2) @(negedge clk);
        check("R5 no start irq", 32'(irq), 32'd0);
        bus_read(8'h10, v); check("R5 command stored", v, 32'h0060_0304);
        bus_read(8'h18, v); check("R5 no start status", v, 32'd0);

        // R9 writes while busy are ignored
        bus_write(8'h00, 32'd2);
        bus_write(8'h00, 32'd4);
        bus_read(8'h14, v); check("R9 busy reads 1", v, 32'd1);
        wait_result();
        bus_read(8'h14, v); check("R9 idle reads 0", v, 32'd0);
        bus_read(8'h00, v); check("R9 second write ignored", v, 32'd2);
        bus_read(8'h04, v); check("R9 request index kept", v, 32'd2);
        bus_read(8'h18, v); check("R9 single result", v, 32'h001);

        // R11 accumulation of two results
        bus_write(8'h00, 32'd0);
        wait_result();
        bus_write(8'h08, 32'd1);
        wait_result();
        bus_read(8'h18, v); check("R11 accumulated flags", v, 32'h011);
        bus_read(8'h08, v); check("R2 cluster 1 index", v, 32'd1);

        // R10 status read on the completion edge
        bus_write(8'h08, 32'd0);
        repeat (LAT - 1) @(negedge clk);
        bus_rd = 1'b1; bus_addr = 8'h18;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R10 same-edge read returns old word", bus_rdata, 32'd0);
        check("R10 same-edge result kept", 32'(irq), 32'd1);
        bus_read(8'h18, v); check("R10 kept flag", v, 32'h010);

        finish_run();
    end
endmodule